// File: doc/BRIEF.md
# Modulo Timer Counter with Reload

This block is a free-running up-counter whose count range is set by software. It starts from a programmable start value, counts up by one on every clock until it reaches a programmable end (modulo) value, and on the next clock returns to the start value. On that return it sets a sticky overflow flag. An interrupt output follows the flag when software enables it.

Software reaches the block through a byte-wide register port. The counter, the start value and the modulo each appear as a high byte and a low byte. A write to either counter byte does not store its data. It restarts the count from the start value. An external synchronization request has the same effect. Every restart produces a one-cycle reload pulse, which channel logic elsewhere uses to return its outputs to their idle levels. A debug-freeze input stops counting so a halted system sees a stable count.

Top module: `modtmr_core`

## Requirements
- R1: When not frozen and not restarted, a count below the modulo value steps up by exactly one on each clock. A count equal to the modulo value returns to the start value on the next clock.
- R2: With start value 0x0000 and modulo 0xFFFF the counter covers the full 16-bit range and goes from 0xFFFF to 0x0000.
- R3: The overflow flag (status bit 7) becomes 1 on the same clock edge on which the count returns from the modulo value to the start value.
- R4: A write to the counter high byte (address 0) or low byte (address 1) loads the start value into the counter on that clock edge. The written data is discarded.
- R5: `sync_req` high at a clock edge loads the start value into the counter on that edge.
- R6: `reload_o` is high during exactly the cycle that follows each clock edge at which a restart (R4 or R5) took effect.
- R7: While `dbg_freeze` is high the count holds its value. A restart still takes effect while frozen.
- R8: The overflow flag stays set until a read strobe of the status register (address 2, `rd_en` high) sees it set and is followed by a write of 0 to status bit 7. A status write that has no such read before it, or that writes 1 to bit 7, leaves the flag set.
- R9: `ovf_irq` is the overflow flag ANDed with the interrupt enable, status bit 6. Every status write loads bit 6.
- R10: If the modulo value is below the start value, the counter reloads the start value on every unfrozen clock. The overflow flag is set on each of those clocks.
- R11: `rdata` follows `addr` combinationally. The map is: 0 counter high, 1 counter low, 2 status, 3 modulo high, 4 modulo low, 5 start high, 6 start low. After reset the counter is 0x0000, the start value is 0x0000, the modulo is 0xFFFF, and the status is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; it only matters for the flag-clear sequence |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sync_req | input | 1 | Synchronization request that restarts the count |
| dbg_freeze | input | 1 | Debug freeze; holds the count |
| count_o | output | 16 | Current count |
| reload_o | output | 1 | One-cycle pulse after each restart |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
The hardest state to reach from the ports is a known count a few steps before a wrap, with a clean flag. The flag sets again whenever the counter runs, and the count itself cannot be written. The stimulus holds `dbg_freeze` high while it programs the start and modulo values, clears the flag, and restarts the count. It then releases the freeze on a known clock, so the count and flag are predicted arithmetically from the cycle index. For the full-range wrap, the bench restarts from start value 0xFFF0 and then rewrites the start value to 0x0000 without restarting. The wrap to zero then arrives after sixteen clocks and not after 65536.

// File: rtl/modtmr_pkg.sv
`timescale 1ns/1ps
package modtmr_pkg;
   typedef enum logic [2:0] {
      A_CNT_HI  = 3'd0,
      A_CNT_LO  = 3'd1,
      A_STAT    = 3'd2,
      A_MOD_HI  = 3'd3,
      A_MOD_LO  = 3'd4,
      A_INIT_HI = 3'd5,
      A_INIT_LO = 3'd6
   } regaddr_e;

   localparam int STAT_FLAG_BIT = 7;
   localparam int STAT_IE_BIT   = 6;
endpackage

// File: rtl/modtmr_counter.sv
`timescale 1ns/1ps
module modtmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_req,
   input  logic             freeze,
   input  logic [CNT_W-1:0] init_val,
   input  logic [CNT_W-1:0] mod_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_evt
);
   logic at_end;

   // reaching or passing the modulo ends the period (covers modulo < start)
   assign at_end   = (cnt_q >= mod_val);
   assign wrap_evt = !reload_req && !freeze && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (reload_req || wrap_evt) cnt_q <= init_val;
      else if (!freeze)                cnt_q <= cnt_q + 1'b1;
   end

   // R1: plain step below the modulo
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload_req && !freeze && !at_end) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R4 / R5: a restart loads the start value
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> cnt_q == $past(init_val));

   // R7: freeze holds the count
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !reload_req) |=> $stable(cnt_q));
endmodule

// File: rtl/modtmr_regs.sv
`timescale 1ns/1ps
module modtmr_regs
   import modtmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              wrap_evt,
   output logic [BYTE_W-1:0] rdata,
   output logic [CNT_W-1:0]  init_val,
   output logic [CNT_W-1:0]  mod_val,
   output logic              cnt_wr,
   output logic              ovf_flag,
   output logic              ovf_ie
);
   localparam int LANES = CNT_W / BYTE_W;

   if (LANES != 2) begin : g_bad_width
      $error("modtmr_regs: CNT_W must be exactly two bytes");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("modtmr_regs: ADDR_W must be at least 3");
   end

   logic wr_stat, rd_stat, armed_q, clr_flag;
   logic unused_wdata;

   assign cnt_wr   = wr_en && ((addr == A_CNT_HI) || (addr == A_CNT_LO));
   assign wr_stat  = wr_en && (addr == A_STAT);
   assign rd_stat  = rd_en && (addr == A_STAT);
   assign clr_flag = wr_stat && !wdata[STAT_FLAG_BIT] && armed_q;
   assign unused_wdata = ^wdata[STAT_IE_BIT-1:0];

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      localparam logic [ADDR_W-1:0] INIT_A = (b == 1) ? A_INIT_HI : A_INIT_LO;
      localparam logic [ADDR_W-1:0] MOD_A  = (b == 1) ? A_MOD_HI  : A_MOD_LO;
      logic [BYTE_W-1:0] init_r, mod_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            init_r <= '0;
            mod_r  <= '1;
         end else if (wr_en) begin
            if (addr == INIT_A) init_r <= wdata;
            if (addr == MOD_A)  mod_r  <= wdata;
         end
      end

      assign init_val[b*BYTE_W +: BYTE_W] = init_r;
      assign mod_val[b*BYTE_W +: BYTE_W]  = mod_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         ovf_ie   <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         if (wrap_evt)      ovf_flag <= 1'b1;
         else if (clr_flag) ovf_flag <= 1'b0;
         if (wr_stat)       ovf_ie   <= wdata[STAT_IE_BIT];
         if (wr_stat)       armed_q  <= 1'b0;
         else if (rd_stat && ovf_flag) armed_q <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CNT_HI:  rdata = cnt_val[CNT_W-1:BYTE_W];
         A_CNT_LO:  rdata = cnt_val[BYTE_W-1:0];
         A_STAT: begin
            rdata[STAT_FLAG_BIT] = ovf_flag;
            rdata[STAT_IE_BIT]   = ovf_ie;
         end
         A_MOD_HI:  rdata = mod_val[CNT_W-1:BYTE_W];
         A_MOD_LO:  rdata = mod_val[BYTE_W-1:0];
         A_INIT_HI: rdata = init_val[CNT_W-1:BYTE_W];
         A_INIT_LO: rdata = init_val[BYTE_W-1:0];
         default:   rdata = '0;
      endcase
   end

   // R3: a wrap raises the flag
   a_r3_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> ovf_flag);

   // R8: without an arming read the flag cannot drop
   a_r8_sticky_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !armed_q) |=> ovf_flag);
endmodule

// File: rtl/modtmr_core.sv
`timescale 1ns/1ps
module modtmr_core #(
   parameter int CNT_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 3,
   parameter bit REG_PULSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              sync_req,
   input  logic              dbg_freeze,
   output logic [CNT_W-1:0]  count_o,
   output logic              reload_o,
   output logic              ovf_irq
);
   logic [CNT_W-1:0] init_val, mod_val;
   logic cnt_wr, wrap_evt, ovf_flag, ovf_ie, reload_req;

   assign reload_req = cnt_wr || sync_req;

   modtmr_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt_val(count_o), .wrap_evt(wrap_evt), .rdata(rdata),
      .init_val(init_val), .mod_val(mod_val), .cnt_wr(cnt_wr),
      .ovf_flag(ovf_flag), .ovf_ie(ovf_ie)
   );

   modtmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .reload_req(reload_req), .freeze(dbg_freeze),
      .init_val(init_val), .mod_val(mod_val), .cnt_q(count_o),
      .wrap_evt(wrap_evt)
   );

   assign ovf_irq = ovf_flag && ovf_ie;

   if (REG_PULSE) begin : g_pulse_reg
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= reload_req;
      end
      assign reload_o = pulse_q;

      // R6: pulse follows each restart for one cycle
      a_r6_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
         reload_req |=> reload_o);
      a_r6_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
         !reload_req |=> !reload_o);
      // R6 / R4: pulse coincides with the start value in the counter
      a_r6_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
         reload_req |=> count_o == $past(init_val));
   end else begin : g_pulse_comb
      assign reload_o = reload_req;
   end
endmodule

// File: tb/modtmr_core_tb.sv
`timescale 1ns/1ps
module modtmr_core_tb;
   import modtmr_pkg::*;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, sync_req = 1'b0, dbg_freeze = 1'b0;
   logic [2:0]  addr = A_STAT;
   logic [7:0]  wdata = '0, rdata;
   logic [15:0] count_o;
   logic        reload_o, ovf_irq;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   modtmr_core u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sync_req(sync_req),
      .dbg_freeze(dbg_freeze), .count_o(count_o), .reload_o(reload_o),
      .ovf_irq(ovf_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // all drive tasks start and end at a falling edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = A_STAT;
      #1;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; addr = A_STAT;
      #1;
   endtask

   task automatic clear_flag();
      logic [7:0] tmp;
      rd(A_STAT, tmp);
      wr(A_STAT, 8'h00);
   endtask

   // frozen setup: program range, clear flag, restart; ends with count=start
   task automatic setup(input logic [15:0] st, input logic [15:0] md);
      dbg_freeze = 1'b1;
      wr(A_INIT_HI, st[15:8]); wr(A_INIT_LO, st[7:0]);
      wr(A_MOD_HI, md[15:8]);  wr(A_MOD_LO, md[7:0]);
      clear_flag();
      chk("R8 flag cleared", rdata[7], 1'b0);
      wr(A_CNT_LO, 8'h5A);
      chk("R4 count loaded, data ignored", count_o, st);
      chk("R6 pulse after counter write", reload_o, 1'b1);
   endtask

   initial begin
      logic [7:0]  v;
      logic [15:0] st, md, expv;
      int          per, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R11 reset count", count_o, 16'h0000);
      chk("R11 reset status", rdata, 8'h00);
      chk("R11 reset irq", ovf_irq, 1'b0);
      chk("R6 reset pulse", reload_o, 1'b0);
      dbg_freeze = 1'b1;
      rd(A_MOD_HI, v);  chk("R11 reset modulo high", v, 8'hFF);
      rd(A_MOD_LO, v);  chk("R11 reset modulo low", v, 8'hFF);
      rd(A_INIT_HI, v); chk("R11 reset start high", v, 8'h00);
      rd(A_INIT_LO, v); chk("R11 reset start low", v, 8'h00);
      chk("R7 frozen after reset", count_o, 16'h0000);

      // sweep of small ranges, including modulo == start and modulo < start (R10)
      for (int p = 0; p < 6; p++) begin
         case (p)
            0: begin st = 16'd0;   md = 16'd7;  end
            1: begin st = 16'd2;   md = 16'd5;  end
            2: begin st = 16'd5;   md = 16'd5;  end
            3: begin st = 16'd3;   md = 16'd12; end
            4: begin st = 16'd6;   md = 16'd3;  end
            default: begin st = 16'h0120; md = 16'h0131; end
         endcase
         setup(st, md);
         per = (md >= st) ? int'(md - st) + 1 : 1;
         @(negedge clk); #1;
         chk("R6 pulse ends", reload_o, 1'b0);
         chk("R7 still frozen", count_o, st);
         dbg_freeze = 1'b0;
         for (int k = 1; k <= 2 * per + 2; k++) begin
            @(negedge clk); #1;
            expv = st + 16'(k % per);
            chk(md < st ? "R10 count stays at start" : "R1 count", count_o, expv);
            chk("R3 flag on wrap", rdata[7], (k >= per) ? 1'b1 : 1'b0);
         end
      end

      // full range wrap R2
      setup(16'hFFF0, 16'hFFFF);
      wr(A_INIT_HI, 8'h00); wr(A_INIT_LO, 8'h00);
      chk("R7 restart held while frozen", count_o, 16'hFFF0);
      dbg_freeze = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk); #1;
         expv = 16'(32'hFFF0 + k);
         chk("R2 full range count", count_o, expv);
         chk("R2 flag at 0xFFFF to 0", rdata[7], (k >= 16) ? 1'b1 : 1'b0);
      end

      // sync request R5
      sync_req = 1'b1;
      @(negedge clk); sync_req = 1'b0; #1;
      chk("R5 sync loads start", count_o, 16'h0000);
      chk("R6 pulse after sync", reload_o, 1'b1);
      @(negedge clk); #1;
      chk("R6 single pulse", reload_o, 1'b0);
      chk("R1 counting after sync", count_o, 16'h0001);

      // freeze R7
      dbg_freeze = 1'b1;
      @(negedge clk); #1;
      c = int'(count_o);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         chk("R7 freeze holds", count_o, 32'(c));
      end
      rd(A_CNT_HI, v); chk("R11 counter high read", v, 8'(c >> 8));
      rd(A_CNT_LO, v); chk("R11 counter low read", v, 8'(c));

      // sticky flag R8 (flag is set from the full-range run)
      chk("R8 flag set", rdata[7], 1'b1);
      wr(A_STAT, 8'h00);
      chk("R8 no clear without read", rdata[7], 1'b1);
      rd(A_STAT, v);
      wr(A_STAT, 8'h80);
      chk("R8 writing 1 keeps flag", rdata[7], 1'b1);
      wr(A_STAT, 8'h00);
      chk("R8 arm consumed by prior write", rdata[7], 1'b1);
      clear_flag();
      chk("R8 read then write 0 clears", rdata[7], 1'b0);

      // interrupt R9
      wr(A_MOD_HI, 8'h00); wr(A_MOD_LO, 8'h01);
      wr(A_CNT_HI, 8'hC3);
      dbg_freeze = 1'b0;
      repeat (3) @(negedge clk);
      dbg_freeze = 1'b1;
      #1;
      chk("R3 flag set again", rdata[7], 1'b1);
      chk("R9 irq masked", ovf_irq, 1'b0);
      wr(A_STAT, 8'h40);
      chk("R9 irq enabled", ovf_irq, 1'b1);
      chk("R9 enable readback", rdata, 8'hC0);
      rd(A_STAT, v);
      wr(A_STAT, 8'h40);
      chk("R9 irq drops with flag", ovf_irq, 1'b0);
      chk("R9 enable kept", rdata, 8'h40);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule